// File: doc/BRIEF.md
# Palette DAC Register Interface

This block holds the colour map of a pseudocolour display: 256 main entries plus 4 overlay entries used for cursor colours, each entry carrying 8-bit red, green and blue. Software reaches the map through a 32-bit register port. It first writes a colour index. It then writes or reads a single data register three times in a row, passing red, green and blue in turn. After blue the index moves on by itself, so a whole block of the palette can be loaded with one index write followed by a stream of data accesses.

A small sequencer with three states tracks which channel comes next: `ST_RED`, `ST_GREEN` and `ST_BLUE`. A data access moves `ST_RED` to `ST_GREEN`, then `ST_GREEN` to `ST_BLUE`, then `ST_BLUE` back to `ST_RED`. That last transition also increments the index modulo 256. An index write forces the sequencer to `ST_RED` from any state. Any other activity leaves the state alone.

A second port, separate from the register port, lets the display pipeline fetch a full 24-bit colour for any of the 260 entries, with one cycle of latency.

Top module: `pal_dac`

## Requirements
- R1: On reset every entry is 0x000000 except entries 255, 256 and 258, which are 0xFFFFFF. The index and the sequencer step are cleared (index 0, step `ST_RED`), and `reg_rdata` and `lk_rgb` read 0.
- R2: A write at byte offset 0x0 loads the index from `reg_wdata[31:24]` and puts the sequencer in `ST_RED`.
- R3: Writes at offset 0x4 store `reg_wdata[31:24]` into the red, then green, then blue channel of main entry `index`, one channel per write.
- R4: A data access made in `ST_BLUE` returns the sequencer to `ST_RED` and increments the index modulo 256, so 255 wraps to 0.
- R5: Writes at offset 0xC go to overlay entry 256 + (index & 3), with the same channel order, step advance and index increment as offset 0x4.
- R6: A read, accepted at any offset, loads `reg_rdata` on the next clock edge. The value is the current channel of main entry `index` in bits [31:24], with zeros in bits [23:0]. The read advances the step and index exactly as a write does.
- R7: Writes at any offset other than 0x0, 0x4 and 0xC are accepted and have no effect on the palette, the index or the step.
- R8: A lookup request presents `lk_rgb` = {R,G,B} (R in bits [23:16]) for entry `lk_idx` on the next clock edge. An index above 259 returns 0. `lk_rgb` holds while no request is made.
- R9: When a register write and a lookup target the same entry in the same cycle, the lookup returns the value the entry held before the write.
- R10: When `reg_wr` and `reg_rd` are both high, the write is performed and the read is dropped: `reg_rdata` holds and the step advances only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Write data; bits [31:24] are used |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| lk_req | input | 1 | Lookup request |
| lk_idx | input | 9 | Lookup entry index (0 to 259) |
| lk_rgb | output | 24 | Looked-up colour {R,G,B} |

## Verification
The bench works on the points where the sequencer is easy to get wrong.

- **Blue step at index 255.** A design that fails to wrap, or that increments on the wrong step, sends the following accesses to the wrong entry.
- **Overlay writes from a high index.** A design that skips the increment, or that does not alias the index onto the four overlay slots, corrupts the main map or the wrong cursor colour.
- **Ignored offsets inside a colour triplet.** A design that lets such a write advance the step shifts the channels that follow.
- **Lookup against a write to the same entry, and a read collided with a write.** A design that forwards the new value, or that double-advances the step, returns the wrong colour.

// File: rtl/pal_dac_pkg.sv
package pal_dac_pkg;

    // Channel sequencer states, in access order.
    typedef enum logic [1:0] {
        ST_RED   = 2'd0,
        ST_GREEN = 2'd1,
        ST_BLUE  = 2'd2
    } step_t;

    // Register byte offsets the block decodes.
    localparam int OFS_INDEX   = 0;
    localparam int OFS_PALETTE = 4;
    localparam int OFS_OVERLAY = 12;

endpackage

// File: rtl/pal_dac_seq.sv
module pal_dac_seq
    import pal_dac_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic             adv_en,
    output step_t            cur_step,
    output logic [IDX_W-1:0] cur_idx
);

    step_t            step_q, step_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= ST_RED;
            idx_q  <= '0;
        end else begin
            step_q <= step_d;
            idx_q  <= idx_d;
        end
    end

    // Next state: an index load wins over a data access.
    always_comb begin
        step_d = step_q;
        idx_d  = idx_q;
        if (ld_en) begin
            step_d = ST_RED;
            idx_d  = ld_idx;
        end else if (adv_en) begin
            unique case (step_q)
                ST_RED:   step_d = ST_GREEN;
                ST_GREEN: step_d = ST_BLUE;
                ST_BLUE: begin
                    step_d = ST_RED;
                    idx_d  = idx_q + 1'b1;
                end
                default:  step_d = ST_RED;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        cur_step = step_q;
        cur_idx  = idx_q;
    end

endmodule

// File: rtl/pal_dac_store.sv
module pal_dac_store
    import pal_dac_pkg::*;
#(
    parameter int CH_W  = 8,
    parameter int IDX_W = 8,
    parameter int N_OVL = 4,
    parameter int LK_W  = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [LK_W-1:0]     wr_ent,
    input  step_t               wr_ch,
    input  logic [CH_W-1:0]     wr_byte,
    input  logic [LK_W-1:0]     rd_ent,
    output logic [3*CH_W-1:0]   rd_rgb,
    input  logic                lk_req,
    input  logic [LK_W-1:0]     lk_idx,
    output logic [3*CH_W-1:0]   lk_rgb
);

    localparam int              N_MAIN  = 2 ** IDX_W;
    localparam int              ENTRIES = N_MAIN + N_OVL;
    localparam int              RGB_W   = 3 * CH_W;
    localparam logic [LK_W-1:0] LAST    = LK_W'(ENTRIES - 1);

    logic [RGB_W-1:0] mem [ENTRIES];

    // Reset colour: white for the last main entry and overlay slots 0 and 2.
    function automatic logic [RGB_W-1:0] init_val(input int e);
        if (e == N_MAIN - 1 || e == N_MAIN || e == N_MAIN + 2)
            return '1;
        return '0;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                mem[e] <= init_val(e);
            end
        end else if (wr_en) begin
            unique case (wr_ch)
                ST_RED:   mem[wr_ent][RGB_W-1 -: CH_W]  <= wr_byte;
                ST_GREEN: mem[wr_ent][2*CH_W-1 -: CH_W] <= wr_byte;
                ST_BLUE:  mem[wr_ent][CH_W-1:0]         <= wr_byte;
                default:  ;
            endcase
        end
    end

    assign rd_rgb = mem[rd_ent];

    // Lookup port: one register stage, sees the pre-write contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_rgb <= '0;
        end else if (lk_req) begin
            lk_rgb <= (lk_idx <= LAST) ? mem[lk_idx] : '0;
        end
    end

endmodule

// File: rtl/pal_dac.sv
module pal_dac
    import pal_dac_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int CH_W   = 8,
    parameter int N_OVL  = 4,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  reg_wr,
    input  logic                                  reg_rd,
    input  logic [ADDR_W-1:0]                     reg_addr,
    input  logic [DATA_W-1:0]                     reg_wdata,
    output logic [DATA_W-1:0]                     reg_rdata,
    input  logic                                  lk_req,
    input  logic [$clog2(2**IDX_W + N_OVL)-1:0]   lk_idx,
    output logic [3*CH_W-1:0]                     lk_rgb
);

    localparam int              ENTRIES  = 2 ** IDX_W + N_OVL;
    localparam int              LK_W     = $clog2(ENTRIES);
    localparam int              RGB_W    = 3 * CH_W;
    localparam int              OVL_W    = (N_OVL > 1) ? $clog2(N_OVL) : 1;
    localparam logic [LK_W-1:0] OVL_BASE = LK_W'(2 ** IDX_W);

    logic [IDX_W-1:0] idx_field;
    logic [CH_W-1:0]  wdat_hi;
    logic             hit_index, hit_pal, hit_ovl, rd_go, adv;
    step_t            cur_step;
    logic [IDX_W-1:0] cur_idx;
    logic [LK_W-1:0]  wr_ent;
    logic [RGB_W-1:0] rd_rgb;
    logic [CH_W-1:0]  rd_byte;
    logic             unused_wdata;

    assign idx_field    = reg_wdata[DATA_W-1 -: IDX_W];
    assign wdat_hi      = reg_wdata[DATA_W-1 -: CH_W];
    assign unused_wdata = ^reg_wdata[DATA_W-CH_W-1:0];

    // Offset decode; unknown offsets fall through with no effect.
    assign hit_index = reg_wr && (reg_addr == ADDR_W'(OFS_INDEX));
    assign hit_pal   = reg_wr && (reg_addr == ADDR_W'(OFS_PALETTE));
    assign hit_ovl   = reg_wr && (reg_addr == ADDR_W'(OFS_OVERLAY));
    assign rd_go     = reg_rd && !reg_wr;
    assign adv       = hit_pal || hit_ovl || rd_go;

    assign wr_ent = hit_ovl ? (OVL_BASE + LK_W'(cur_idx[OVL_W-1:0]))
                            : LK_W'(cur_idx);

    pal_dac_seq #(
        .IDX_W (IDX_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (hit_index),
        .ld_idx   (idx_field),
        .adv_en   (adv),
        .cur_step (cur_step),
        .cur_idx  (cur_idx)
    );

    pal_dac_store #(
        .CH_W  (CH_W),
        .IDX_W (IDX_W),
        .N_OVL (N_OVL),
        .LK_W  (LK_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (hit_pal || hit_ovl),
        .wr_ent  (wr_ent),
        .wr_ch   (cur_step),
        .wr_byte (wdat_hi),
        .rd_ent  (LK_W'(cur_idx)),
        .rd_rgb  (rd_rgb),
        .lk_req  (lk_req),
        .lk_idx  (lk_idx),
        .lk_rgb  (lk_rgb)
    );

    // Channel pick for register reads.
    always_comb begin
        unique case (cur_step)
            ST_RED:   rd_byte = rd_rgb[RGB_W-1 -: CH_W];
            ST_GREEN: rd_byte = rd_rgb[2*CH_W-1 -: CH_W];
            ST_BLUE:  rd_byte = rd_rgb[CH_W-1:0];
            default:  rd_byte = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (rd_go) begin
            reg_rdata <= {rd_byte, {(DATA_W-CH_W){1'b0}}};
        end
    end

endmodule

// File: rtl/pal_dac_chk.sv
module pal_dac_chk
    import pal_dac_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int RGB_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              lk_req,
    input logic [RGB_W-1:0]  lk_rgb,
    input logic [IDX_W-1:0]  idx_field,
    input logic [IDX_W-1:0]  cur_idx,
    input step_t             cur_step
);

    logic is_idx, is_data, is_other, acc;
    assign is_idx   = reg_addr == ADDR_W'(OFS_INDEX);
    assign is_data  = (reg_addr == ADDR_W'(OFS_PALETTE)) || (reg_addr == ADDR_W'(OFS_OVERLAY));
    assign is_other = !is_idx && !is_data;
    assign acc      = (reg_wr && is_data) || (reg_rd && !reg_wr);

    AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && is_idx |=> cur_idx == $past(idx_field) && cur_step == ST_RED); // R2

    AST_STEP_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        acc && cur_step == ST_RED |=> cur_step == ST_GREEN); // R3

    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        acc && cur_step == ST_BLUE |=> cur_step == ST_RED && cur_idx == IDX_W'($past(cur_idx) + 1'b1)); // R4

    AST_IGNORED_OFS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && is_other |=> $stable(cur_idx) && $stable(cur_step)); // R7

    AST_RD_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && !reg_wr |=> reg_rdata[DATA_W-9:0] == '0); // R6

    AST_LK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> $stable(lk_rgb)); // R8

    AST_RD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && !reg_wr) |=> $stable(reg_rdata)); // R10

endmodule

bind pal_dac pal_dac_chk #(
    .IDX_W  (IDX_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .RGB_W  (RGB_W)
) u_chk (.*);

// File: tb/pal_dac_bench.sv
`timescale 1ns/1ps
module pal_dac_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, lk_req = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [8:0]  lk_idx = '0;
    logic [23:0] lk_rgb;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    pal_dac u_pal_dac (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lk_req(lk_req), .lk_idx(lk_idx), .lk_rgb(lk_rgb)
    );

    // Vector: {req tag, op (1 write, 2 read), offset, data byte, expected byte}
    localparam int NV = 31;
    localparam logic [27:0] VEC [NV] = '{
        28'h2_1_0_10_00, 28'h3_1_4_11_00, 28'h3_1_4_22_00, 28'h3_1_4_33_00,
        28'h2_1_0_10_00, 28'h6_2_0_00_11, 28'h6_2_0_00_22, 28'h6_2_0_00_33,
        28'h4_2_0_00_00, 28'h2_1_0_FF_00, 28'h1_2_0_00_FF, 28'h1_2_0_00_FF,
        28'h1_2_0_00_FF, 28'h4_2_0_00_AB, 28'h2_1_0_FF_00, 28'h3_1_4_A1_00,
        28'h3_1_4_A2_00, 28'h3_1_4_A3_00, 28'h4_1_4_5A_00, 28'h2_1_0_00_00,
        28'h4_2_0_00_5A, 28'h2_1_0_20_00, 28'h3_1_4_01_00, 28'h7_1_8_77_00,
        28'h7_1_2_77_00, 28'h3_1_4_02_00, 28'h3_1_4_03_00, 28'h2_1_0_20_00,
        28'h7_2_0_00_01, 28'h7_2_0_00_02, 28'h7_2_0_00_03
    };

    function automatic string tag_of(input logic [3:0] t);
        case (t)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd6:    return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = {d, 24'h0};
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_rd(output logic [31:0] v);
        @(negedge clk);
        reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    task automatic do_lk(input logic [8:0] i, output logic [23:0] v);
        @(negedge clk);
        lk_req = 1'b1; lk_idx = i;
        @(negedge clk);
        lk_req = 1'b0;
        v = lk_rgb;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; lk_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [23:0] c;
        logic [31:0] held;

        do_reset();
        // R1: reset state at the ports
        check("R1 rdata", reg_rdata, 32'h0);
        check("R1 lk_rgb", {8'h0, lk_rgb}, 32'h0);
        do_lk(9'd0,   c); check("R1 entry0",   {8'h0, c}, 32'h000000);
        do_lk(9'd255, c); check("R1 entry255", {8'h0, c}, 32'hFFFFFF);
        do_lk(9'd256, c); check("R1 entry256", {8'h0, c}, 32'hFFFFFF);
        do_lk(9'd257, c); check("R1 entry257", {8'h0, c}, 32'h000000);
        do_lk(9'd258, c); check("R1 entry258", {8'h0, c}, 32'hFFFFFF);
        do_lk(9'd259, c); check("R1 entry259", {8'h0, c}, 32'h000000);
        // R1: index 0 and red step after reset
        do_wr(4'h4, 8'hAB);
        do_lk(9'd0, c); check("R1 index/step cleared", {8'h0, c}, 32'hAB0000);

        // Table: R2 R3 R4 R6 R7 sequences
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][23:20] == 4'd1) begin
                do_wr(VEC[i][19:16], VEC[i][15:8]);
            end else begin
                do_rd(r);
                check($sformatf("%s vector %0d", tag_of(VEC[i][27:24]), i), r, {VEC[i][7:0], 24'h0});
            end
        end
        do_lk(9'd255, c); check("R4 wrapped block at 255", {8'h0, c}, 32'hA1A2A3);

        // R5: overlay aliasing and increment
        do_wr(4'h0, 8'h06);
        do_wr(4'hC, 8'h44); do_wr(4'hC, 8'h55); do_wr(4'hC, 8'h66);
        do_wr(4'h4, 8'h99);
        do_lk(9'd7, c);   check("R5 index advanced after overlay", {8'h0, c}, 32'h990000);
        do_lk(9'd6, c);   check("R5 main entry untouched", {8'h0, c}, 32'h000000);
        do_wr(4'h0, 8'hFD);
        do_wr(4'hC, 8'h12); do_wr(4'hC, 8'h34); do_wr(4'hC, 8'h56);
        do_lk(9'd257, c); check("R5 overlay from high index", {8'h0, c}, 32'h123456);
        do_lk(9'd258, c); check("R5 overlay 258", {8'h0, c}, 32'h445566);

        // R8: hold and out-of-range index
        repeat (3) @(negedge clk);
        check("R8 hold without request", {8'h0, lk_rgb}, 32'h445566);
        do_lk(9'd300, c); check("R8 out of range", {8'h0, c}, 32'h000000);

        // R9: same-cycle write and lookup of one entry
        do_wr(4'h0, 8'h40);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'h4; reg_wdata = 32'h77000000;
        lk_req = 1'b1; lk_idx = 9'h40;
        @(negedge clk);
        reg_wr = 1'b0; lk_req = 1'b0;
        check("R9 old value on collision", {8'h0, lk_rgb}, 32'h000000);
        do_lk(9'h40, c); check("R9 new value after", {8'h0, c}, 32'h770000);

        // R10: read colliding with a write
        do_wr(4'h0, 8'h50);
        do_wr(4'h4, 8'h88);
        held = reg_rdata;
        @(negedge clk);
        reg_wr = 1'b1; reg_rd = 1'b1; reg_addr = 4'h4; reg_wdata = 32'h99000000;
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0;
        check("R10 rdata holds", reg_rdata, held);
        do_wr(4'h4, 8'h11);
        do_lk(9'h50, c); check("R10 single step advance", {8'h0, c}, 32'h889911);

        // R1: reset in mid-use restores defaults
        do_wr(4'h0, 8'h00);
        do_wr(4'h4, 8'hEE);
        do_reset();
        check("R1 rdata after reset", reg_rdata, 32'h0);
        do_lk(9'd0,   c); check("R1 entry0 after reset", {8'h0, c}, 32'h000000);
        do_lk(9'd255, c); check("R1 entry255 after reset", {8'h0, c}, 32'hFFFFFF);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule